// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects single-cycle event pulses from a set of peripheral sources and turns them into one interrupt request towards a processor. Each source has a sticky pending flag, a mask bit, a bit that hands the source to a DMA engine instead of the processor, and a programmable 3-bit priority level. Among the sources that are pending, unmasked and not handed to DMA, the one with the highest level wins. Its level and its vector number (a base offset plus the source index) go out together with the request.

The request is level style. It stays up while the winning source remains qualified, and only a clear of its flag, a clear of its mask bit, or a stronger qualifying source changes it. Taking the interrupt does not lower it. Software reaches every control bit through a small synchronous register port with a combinational read path. A separate per-source output, flag AND mask, drives the DMA trigger and wake-up logic.

Top module: `irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt_i[i]` sets flag i on that clock edge, whatever the mask and DMA bits hold. When an event and a clear of the same flag meet in one cycle, the flag ends up set.
- R2: A write to address 0 clears each flag whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R3: Register map, with bit i belonging to source i: address 0 reads the flags, address 1 is the mask-enable register, address 2 is the DMA-routing register, and address 3 holds the levels (source i at bits 3i+2..3i). Addresses 1 to 3 read back what was last written. Unused read bits are 0, and everything resets to 0.
- R4: A source qualifies only when its flag is 1, its enable bit is 1 and its routing bit is 0. `irq_o` is 1 exactly when at least one source qualifies.
- R5: The qualifying source with the numerically highest level wins. Among equal levels, the lowest index wins.
- R6: While `irq_o` is 1, `irq_lvl_o` carries the winner's level and `irq_vec_o` carries VEC_BASE plus the winner's index, in the same cycle as the state that produced them.
- R7: The request, level and vector stay unchanged over any number of cycles until the winner's flag or enable bit is cleared or a stronger source qualifies. No acknowledge path exists.
- R8: While no source qualifies, `irq_o` and `irq_lvl_o` are 0 and `irq_vec_o` keeps the vector of the last winner (VEC_BASE after reset).
- R9: `dma_req_o[i]` equals flag i AND enable bit i, independent of the routing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_SRC | Per-source event pulses |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i` |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_lvl_o | output | LVL_W | Level of the winning source |
| irq_vec_o | output | VEC_W | Vector number of the winning source |
| dma_req_o | output | N_SRC | Per-source DMA / wake trigger |

## Verification
A wrong flag, mask or routing bit shows in the read data on the next cycle the register is addressed. It also shows in the same cycle on `dma_req_o` or on the request once the source is unmasked. A broken priority compare gives a wrong vector or level in the first cycle where two qualifying sources differ or tie. A missing vector hold register shows in the first idle cycle after a request drops. The reference model is compared against every output on every cycle under mixed directed and random traffic, so each of these faults is caught within a cycle of becoming visible.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_FLAG  = 2'd0,
    REG_ENA   = 2'd1,
    REG_ROUTE = 2'd2,
    REG_LEVEL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             clr_i,
  input  logic             ena_we_i,
  input  logic             ena_d_i,
  input  logic             route_we_i,
  input  logic             route_d_i,
  input  logic             lvl_we_i,
  input  logic [LVL_W-1:0] lvl_d_i,
  output logic             flag_o,
  output logic             ena_o,
  output logic             route_o,
  output logic [LVL_W-1:0] lvl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o  <= 1'b0;
      ena_o   <= 1'b0;
      route_o <= 1'b0;
      lvl_o   <= '0;
    end else begin
      // event has priority over clear
      if (evt_i)      flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
      if (ena_we_i)   ena_o   <= ena_d_i;
      if (route_we_i) route_o <= route_d_i;
      if (lvl_we_i)   lvl_o   <= lvl_d_i;
    end
  end
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int LVL_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [N_SRC-1:0]       flag_i,
  input  logic [N_SRC-1:0]       ena_i,
  input  logic [N_SRC-1:0]       route_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  output logic [N_SRC-1:0]       flag_clr_o,
  output logic                   ena_we_o,
  output logic                   route_we_o,
  output logic                   lvl_we_o,
  output logic [DATA_W-1:0]      rdata_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  assign flag_clr_o = (we_i && sel == REG_FLAG) ? wdata_i[N_SRC-1:0] : '0;
  assign ena_we_o   = we_i && sel == REG_ENA;
  assign route_we_o = we_i && sel == REG_ROUTE;
  assign lvl_we_o   = we_i && sel == REG_LEVEL;

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_FLAG:  rdata_o[N_SRC-1:0]       = flag_i;
      REG_ENA:   rdata_o[N_SRC-1:0]       = ena_i;
      REG_ROUTE: rdata_o[N_SRC-1:0]       = route_i;
      REG_LEVEL: rdata_o[N_SRC*LVL_W-1:0] = lvl_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       qual_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [LVL_W-1:0]       lvl_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    lvl_o = '0;
    // strict greater-than keeps the lower index on ties
    for (int i = 0; i < N_SRC; i++) begin
      if (qual_i[i] && (!any_o || lvl_i[i*LVL_W +: LVL_W] > lvl_o)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int LVL_W    = 3,
  parameter int DATA_W   = 32,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [N_SRC-1:0]  dma_req_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0]       flag_q, ena_q, route_q, flag_clr, qual;
  logic [N_SRC*LVL_W-1:0] lvl_flat;
  logic                   ena_we, route_we, lvl_we, win_any;
  logic [IDX_W-1:0]       win_idx;
  logic [LVL_W-1:0]       win_lvl;
  logic [VEC_W-1:0]       win_vec, vec_q;

  irq_regif #(.N_SRC(N_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_regif (
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .flag_i(flag_q), .ena_i(ena_q), .route_i(route_q), .lvl_i(lvl_flat),
    .flag_clr_o(flag_clr), .ena_we_o(ena_we), .route_we_o(route_we),
    .lvl_we_o(lvl_we), .rdata_o(bus_rdata_o)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irq_src_cell #(.LVL_W(LVL_W)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .evt_i(evt_i[i]), .clr_i(flag_clr[i]),
      .ena_we_i(ena_we), .ena_d_i(bus_wdata_i[i]),
      .route_we_i(route_we), .route_d_i(bus_wdata_i[i]),
      .lvl_we_i(lvl_we), .lvl_d_i(bus_wdata_i[i*LVL_W +: LVL_W]),
      .flag_o(flag_q[i]), .ena_o(ena_q[i]), .route_o(route_q[i]),
      .lvl_o(lvl_flat[i*LVL_W +: LVL_W])
    );
  end

  assign qual      = flag_q & ena_q & ~route_q;
  assign dma_req_o = flag_q & ena_q;

  irq_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .qual_i(qual), .lvl_i(lvl_flat),
    .any_o(win_any), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  assign win_vec = VEC_W'(VEC_BASE) + VEC_W'(win_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vec_q <= VEC_W'(VEC_BASE);
    else if (win_any) vec_q <= win_vec;
  end

  assign irq_o     = win_any;
  assign irq_lvl_o = win_any ? win_lvl : '0;
  assign irq_vec_o = win_any ? win_vec : vec_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N_SRC    = 8,
  parameter int LVL_W    = 3,
  parameter int DATA_W   = 32,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_SRC-1:0]       evt_i,
  input logic                   bus_we_i,
  input logic [1:0]             bus_addr_i,
  input logic [DATA_W-1:0]      bus_wdata_i,
  input logic                   irq_o,
  input logic [LVL_W-1:0]       irq_lvl_o,
  input logic [VEC_W-1:0]       irq_vec_o,
  input logic [N_SRC-1:0]       flag_q,
  input logic [N_SRC-1:0]       ena_q,
  input logic [N_SRC-1:0]       route_q,
  input logic [N_SRC*LVL_W-1:0] lvl_flat
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  logic [IDX_W-1:0] w_idx;
  assign w_idx = IDX_W'(irq_vec_o - VEC_W'(VEC_BASE));

  AST_FLAG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R1

  AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 2'd0) |=>
      ((flag_q & $past(bus_wdata_i[N_SRC-1:0] & ~evt_i)) == '0)); // R2

  AST_WINNER_QUALIFIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_q[w_idx] && ena_q[w_idx] && !route_q[w_idx])); // R4

  AST_WINNER_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_lvl_o == lvl_flat[w_idx*LVL_W +: LVL_W])); // R6

  AST_IDLE_LEVEL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_lvl_o == '0)); // R8

  AST_IDLE_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> $stable(irq_vec_o)); // R8
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .N_SRC(N_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .irq_o(irq_o),
  .irq_lvl_o(irq_lvl_o), .irq_vec_o(irq_vec_o), .flag_q(flag_q),
  .ena_q(ena_q), .route_q(route_q), .lvl_flat(lvl_flat)
);

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  localparam int N = 8;
  localparam int VB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [2:0]  lvl;
  logic [7:0]  vec;
  logic [N-1:0] dma;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_flag[N], m_ena[N], m_route[N], m_lvl[N];
  int m_last_vec = VB;
  int obs_vec, obs_irq;

  always #2.5 clk = ~clk;

  irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .irq_lvl_o(lvl),
    .irq_vec_o(vec), .dma_req_o(dma)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare, advance model
  task automatic step(input logic [N-1:0] e, input logic w, input logic [1:0] a,
                      input logic [31:0] d);
    int best, bl, exp_rd, exp_dma;
    @(negedge clk);
    evt = e; we = w; addr = a; wdata = d;
    #1;
    best = -1; bl = 0;
    for (int i = 0; i < N; i++)
      if (m_flag[i] == 1 && m_ena[i] == 1 && m_route[i] == 0 && (best < 0 || m_lvl[i] > bl)) begin
        best = i; bl = m_lvl[i];
      end
    if (best >= 0) m_last_vec = VB + best;
    exp_rd = 0; exp_dma = 0;
    for (int i = 0; i < N; i++) begin
      case (a)
        2'd0: exp_rd |= m_flag[i] << i;
        2'd1: exp_rd |= m_ena[i] << i;
        2'd2: exp_rd |= m_route[i] << i;
        default: exp_rd |= m_lvl[i] << (3 * i);
      endcase
      exp_dma |= (m_flag[i] & m_ena[i]) << i;
    end
    chk("R4 irq", int'(irq), best >= 0 ? 1 : 0);
    chk(best >= 0 ? "R6 level" : "R8 level", int'(lvl), best >= 0 ? bl : 0);
    chk(best >= 0 ? "R6 vector" : "R8 vector", int'(vec), m_last_vec);
    chk("R9 dma", int'(dma), exp_dma);
    chk(a == 2'd0 ? "R1 flag read" : "R3 read", int'(rdata), exp_rd);
    obs_vec = int'(vec); obs_irq = int'(irq);
    for (int i = 0; i < N; i++) begin
      if (w && a == 2'd0 && d[i]) m_flag[i] = 0;
      if (e[i]) m_flag[i] = 1;
      if (w && a == 2'd1) m_ena[i] = int'(d[i]);
      if (w && a == 2'd2) m_route[i] = int'(d[i]);
      if (w && a == 2'd3) m_lvl[i] = int'(d[3*i +: 3]);
    end
  endtask

  task automatic idle_expect(input string tag, input int exp_irq, input int exp_vec);
    step('0, 1'b0, 2'd0, '0);
    chk(tag, obs_irq, exp_irq);
    chk(tag, obs_vec, exp_vec);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_flag[i] = 0; m_ena[i] = 0; m_route[i] = 0; m_lvl[i] = 0;
    end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state of all registers (R3, R8)
    for (int a = 0; a < 4; a++) step('0, 1'b0, 2'(a), '0);
    // R1: flags set while masked, no request
    step(8'hFF, 1'b0, 2'd0, '0);
    idle_expect("R1 masked", 0, VB);
    // R5: equal levels, lowest index wins
    step('0, 1'b1, 2'd1, 32'hFF);
    idle_expect("R5 tie", 1, VB);
    // R5: higher level beats lower index
    step('0, 1'b1, 2'd3, (32'd5 << 9) | (32'd5 << 18));
    idle_expect("R5 level", 1, VB + 3);
    // R7: held with no further activity
    for (int k = 0; k < 6; k++) idle_expect("R7 hold", 1, VB + 3);
    // R4: routing to DMA removes source 3
    step('0, 1'b1, 2'd2, 32'h08);
    idle_expect("R4 route", 1, VB + 6);
    // R2: clear source 6 only
    step('0, 1'b1, 2'd0, 32'h40);
    idle_expect("R2 clear", 1, VB);
    // R8: clear all, vector holds last
    step('0, 1'b1, 2'd0, 32'hFF);
    idle_expect("R8 idle", 0, VB);
    // R1: set wins over clear
    step(8'h04, 1'b1, 2'd0, 32'h04);
    idle_expect("R1 set wins", 1, VB + 2);
    step('0, 1'b1, 2'd1, 32'h00);
    idle_expect("R7 disable", 0, VB + 2);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] e;
      logic w;
      e = ($urandom_range(0, 3) == 0) ? N'($urandom) & N'($urandom) : '0;
      w = ($urandom_range(0, 2) == 0);
      step(e, w, 2'($urandom), $urandom);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule